// File: doc/BRIEF.md
# Machine-Check Error Severity Classifier

This block receives memory and cache error events, one per cycle at most, and assigns each one a machine-check severity class. Each event carries the unit that saw the error, whether the hardware corrected it, whether the bad data has already been consumed, and whether the processor context is corrupt. The block decides recoverability from the detecting unit and the consumption state, and not only from the corrected or uncorrected status. It then picks the reporting path. Recoverable and fatal errors raise a one-cycle exception pulse. Corrected and no-action errors raise a one-cycle corrected-error interrupt pulse.

With each event the block also reports the 4 KB page frame that recovery software would act on. A single status log entry keeps the first unread event, including its detecting unit, so that an instruction-fetch action-required error stays distinct from a data-cache one. Later events set an overflow flag. A later event that is strictly more severe than the held entry replaces it. Software empties the entry with a clear strobe.

Top module: `mce_classifier`

## Requirements
- R1: A corrected event (`evtUncorr`=0) is classified CE (code 0) and raises `cmciPulse`, whatever its other inputs are.
- R2: An uncorrected event from the data cache unit (source 0) or instruction fetch unit (source 1) with `evtConsumed`=1 and no context corruption is classified SRAR (code 3) and raises `excPulse`.
- R3: An uncorrected event from the patrol scrubber (source 2) or an explicit last-level-cache writeback (source 3), with no context corruption, is classified SRAO (code 2) and raises `excPulse`, consumed or not.
- R4: An uncorrected, unconsumed event from source 0, 1 or 4..7, with no context corruption, is classified UCNA (code 1) and raises `cmciPulse`.
- R5: Any uncorrected event with `evtCtxCorrupt`=1, and any consumed uncorrected event from source 4..7, is classified UC (code 4), raises `excPulse` and sets `fatalFlag`.
- R6: Class, pulses, fatal flag and page frame appear exactly one clock after the event is accepted, for one cycle.
- R7: `pageFrame` equals the event address shifted right by 12 bits.
- R8: An event arriving while the log is empty loads the log with its class, source and page frame, sets `logValid`, and leaves `logOverflow` at 0.
- R9: An event arriving while the log holds an entry sets `logOverflow`, which stays set until a clear.
- R10: An event arriving while the log holds an entry replaces that entry only if its class code is strictly greater. An equal or lower code leaves class, source and frame unchanged.
- R11: `logClear` empties the log and drops the overflow flag. An event in the same cycle as the clear is logged as though the log were empty.
- R12: After reset all outputs are 0.
- R13: Exactly one of `excPulse` and `cmciPulse` is high in the cycle after each event, and neither is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Error event present this cycle |
| evtSource | input | 3 | Detecting unit: 0 data cache, 1 instruction fetch, 2 patrol scrub, 3 LLC explicit writeback, 4..7 other |
| evtUncorr | input | 1 | 1 if the error was not corrected |
| evtConsumed | input | 1 | 1 if the corrupt data was consumed |
| evtCtxCorrupt | input | 1 | 1 if the processor context is corrupt |
| evtAddr | input | ADDR_W | Physical address of the error |
| logClear | input | 1 | Empty the status log |
| classValid | output | 1 | Class outputs are valid this cycle |
| classCode | output | 3 | 0 CE, 1 UCNA, 2 SRAO, 3 SRAR, 4 UC |
| excPulse | output | 1 | Machine-check exception pulse |
| cmciPulse | output | 1 | Corrected-error interrupt pulse |
| fatalFlag | output | 1 | Reported event is fatal (UC) |
| pageFrame | output | ADDR_W-12 | 4 KB page frame of the reported event |
| logValid | output | 1 | Status log holds an unread entry |
| logOverflow | output | 1 | Events arrived while the log was full |
| logClass | output | 3 | Class of the logged entry |
| logSource | output | 3 | Detecting unit of the logged entry |
| logFrame | output | ADDR_W-12 | Page frame of the logged entry |

## Verification
Every combination of source code, corrected status, consumed flag and context-corruption flag is applied, 64 patterns in all, each to an empty log. These patterns separate the decision made on the detecting unit from the one made on the consumed flag, and show that context corruption overrides both. A scripted sequence then offers events of lower, equal and higher severity to a full log. It tells overflow apart from replacement, and shows that an equal-severity data-cache error cannot displace a logged instruction-fetch error. A clear in the same cycle as an event is checked separately from a plain clear.

// File: rtl/mce_pkg.sv
package mce_pkg;

  typedef enum logic [2:0] {
    CLS_CE   = 3'd0,
    CLS_UCNA = 3'd1,
    CLS_SRAO = 3'd2,
    CLS_SRAR = 3'd3,
    CLS_UC   = 3'd4
  } mce_class_e;

  localparam logic [2:0] SRC_DCU    = 3'd0;
  localparam logic [2:0] SRC_IFU    = 3'd1;
  localparam logic [2:0] SRC_PATROL = 3'd2;
  localparam logic [2:0] SRC_LLCWB  = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       report;
    logic       raiseExc;
    logic       raiseCmci;
    logic       fatal;
    logic       loadLog;
    logic       setOvf;
    logic       clearLog;
    mce_class_e cls;
  } mce_strobe_t;

endpackage

// File: rtl/mce_ctrl.sv
module mce_ctrl
  import mce_pkg::*;
(
  input  logic        evtValid,
  input  logic [2:0]  evtSource,
  input  logic        evtUncorr,
  input  logic        evtConsumed,
  input  logic        evtCtxCorrupt,
  input  logic        logClear,
  input  logic        logValid,
  input  logic [2:0]  logClass,
  output mce_strobe_t strobes
);

  mce_class_e cls;
  logic       fromCore;
  logic       fromBackground;
  logic       entryHeld;
  logic       excClass;

  always_comb begin
    fromCore       = (evtSource == SRC_DCU) || (evtSource == SRC_IFU);
    fromBackground = (evtSource == SRC_PATROL) || (evtSource == SRC_LLCWB);
    if (!evtUncorr)                    cls = CLS_CE;
    else if (evtCtxCorrupt)            cls = CLS_UC;
    else if (fromCore && evtConsumed)  cls = CLS_SRAR;
    else if (fromBackground)           cls = CLS_SRAO;
    else if (!evtConsumed)             cls = CLS_UCNA;
    else                               cls = CLS_UC;
  end

  always_comb begin
    entryHeld = logValid && !logClear;
    excClass  = (cls == CLS_SRAR) || (cls == CLS_SRAO) || (cls == CLS_UC);
    strobes           = '0;
    strobes.cls       = cls;
    strobes.report    = evtValid;
    strobes.raiseExc  = evtValid && excClass;
    strobes.raiseCmci = evtValid && !excClass;
    strobes.fatal     = evtValid && (cls == CLS_UC);
    strobes.loadLog   = evtValid && (!entryHeld || (3'(cls) > logClass));
    strobes.setOvf    = evtValid && entryHeld;
    strobes.clearLog  = logClear;
  end

endmodule

// File: rtl/mce_datapath.sv
module mce_datapath
  import mce_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 12,
  localparam int FRAME_W   = ADDR_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mce_strobe_t        strobes,
  input  logic [2:0]         evtSource,
  input  logic [ADDR_W-1:0]  evtAddr,
  output logic               classValid,
  output logic [2:0]         classCode,
  output logic               excPulse,
  output logic               cmciPulse,
  output logic               fatalFlag,
  output logic [FRAME_W-1:0] pageFrame,
  output logic               logValid,
  output logic               logOverflow,
  output logic [2:0]         logClass,
  output logic [2:0]         logSource,
  output logic [FRAME_W-1:0] logFrame
);

  logic [FRAME_W-1:0] evtFrame;
  assign evtFrame = evtAddr[ADDR_W-1:PAGE_SHIFT];

  // per-event report, one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      classValid <= 1'b0;
      classCode  <= '0;
      excPulse   <= 1'b0;
      cmciPulse  <= 1'b0;
      fatalFlag  <= 1'b0;
      pageFrame  <= '0;
    end else begin
      classValid <= strobes.report;
      excPulse   <= strobes.raiseExc;
      cmciPulse  <= strobes.raiseCmci;
      fatalFlag  <= strobes.fatal;
      if (strobes.report) begin
        classCode <= strobes.cls;
        pageFrame <= evtFrame;
      end
    end
  end

  // single-entry status log
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      logValid    <= 1'b0;
      logOverflow <= 1'b0;
      logClass    <= '0;
      logSource   <= '0;
      logFrame    <= '0;
    end else begin
      if (strobes.loadLog) begin
        logValid  <= 1'b1;
        logClass  <= strobes.cls;
        logSource <= evtSource;
        logFrame  <= evtFrame;
      end else if (strobes.clearLog) begin
        logValid  <= 1'b0;
      end
      if (strobes.setOvf)        logOverflow <= 1'b1;
      else if (strobes.clearLog) logOverflow <= 1'b0;
    end
  end

  // R13: exactly one reporting path per event
  a_r13_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    classValid |-> $onehot({excPulse, cmciPulse}));
  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !classValid |-> !excPulse && !cmciPulse);
  // R5: fatal only with the exception and the UC class
  a_r5_fatal_uc: assert property (@(posedge clk) disable iff (!rst_n)
    fatalFlag |-> excPulse && classCode == 3'd4);
  // R8: an accepted event always leaves a valid log entry
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.report) |-> logValid);
  // R9: overflow sticks until cleared and implies a held entry
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(logOverflow) && !$past(strobes.clearLog) |-> logOverflow);
  a_r9_ovf_valid: assert property (@(posedge clk) disable iff (!rst_n)
    logOverflow |-> logValid);
  // R10: a held entry never drops in severity
  a_r10_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    $past(logValid) && !$past(strobes.clearLog) |-> logValid && logClass >= $past(logClass));

endmodule

// File: rtl/mce_classifier.sv
module mce_classifier
  import mce_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 12,
  localparam int FRAME_W   = ADDR_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evtValid,
  input  logic [2:0]         evtSource,
  input  logic               evtUncorr,
  input  logic               evtConsumed,
  input  logic               evtCtxCorrupt,
  input  logic [ADDR_W-1:0]  evtAddr,
  input  logic               logClear,
  output logic               classValid,
  output logic [2:0]         classCode,
  output logic               excPulse,
  output logic               cmciPulse,
  output logic               fatalFlag,
  output logic [FRAME_W-1:0] pageFrame,
  output logic               logValid,
  output logic               logOverflow,
  output logic [2:0]         logClass,
  output logic [2:0]         logSource,
  output logic [FRAME_W-1:0] logFrame
);

  mce_strobe_t strobes;

  mce_ctrl i_ctrl (
    .evtValid      (evtValid),
    .evtSource     (evtSource),
    .evtUncorr     (evtUncorr),
    .evtConsumed   (evtConsumed),
    .evtCtxCorrupt (evtCtxCorrupt),
    .logClear      (logClear),
    .logValid      (logValid),
    .logClass      (logClass),
    .strobes       (strobes)
  );

  mce_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .evtSource   (evtSource),
    .evtAddr     (evtAddr),
    .classValid  (classValid),
    .classCode   (classCode),
    .excPulse    (excPulse),
    .cmciPulse   (cmciPulse),
    .fatalFlag   (fatalFlag),
    .pageFrame   (pageFrame),
    .logValid    (logValid),
    .logOverflow (logOverflow),
    .logClass    (logClass),
    .logSource   (logSource),
    .logFrame    (logFrame)
  );

endmodule

// File: tb/test_mce_classifier.sv
`timescale 1ns/1ps
module test_mce_classifier;

  localparam int ADDR_W  = 40;
  localparam int FRAME_W = ADDR_W - 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               evtValid = 1'b0;
  logic [2:0]         evtSource = '0;
  logic               evtUncorr = 1'b0;
  logic               evtConsumed = 1'b0;
  logic               evtCtxCorrupt = 1'b0;
  logic [ADDR_W-1:0]  evtAddr = '0;
  logic               logClear = 1'b0;
  logic               classValid, excPulse, cmciPulse, fatalFlag;
  logic [2:0]         classCode, logClass, logSource;
  logic [FRAME_W-1:0] pageFrame, logFrame;
  logic               logValid, logOverflow;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mce_classifier #(.ADDR_W(ADDR_W)) i_mce_classifier (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expClass(input logic [2:0] s, input bit u, input bit c, input bit x);
    if (!u) return 3'd0;
    if (x) return 3'd4;
    if (s <= 3'd1 && c) return 3'd3;
    if (s == 3'd2 || s == 3'd3) return 3'd2;
    if (!c) return 3'd1;
    return 3'd4;
  endfunction

  // drive at negedge; results visible at the following negedge
  task automatic sendEvent(input logic [2:0] s, input bit u, input bit c, input bit x,
                           input logic [ADDR_W-1:0] a, input bit clr);
    evtValid = 1'b1; evtSource = s; evtUncorr = u; evtConsumed = c;
    evtCtxCorrupt = x; evtAddr = a; logClear = clr;
    @(negedge clk);
    evtValid = 1'b0; logClear = 1'b0;
  endtask

  task automatic doClear();
    logClear = 1'b1;
    @(negedge clk);
    logClear = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!classValid && !excPulse && !cmciPulse && !fatalFlag && classCode == 0 && pageFrame == 0,
        "R12 report outputs", {classValid, excPulse, cmciPulse, fatalFlag}, 0);
    chk(!logValid && !logOverflow && logClass == 0 && logSource == 0 && logFrame == 0,
        "R12 log outputs", {logValid, logOverflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!classValid && !excPulse && !cmciPulse, "R13 idle quiet", {excPulse, cmciPulse}, 0);

    // exhaustive sweep over source, corrected, consumed, context-corrupt
    for (int i = 0; i < 64; i++) begin
      logic [2:0] s = i[2:0];
      bit u = i[3], c = i[4], x = i[5];
      logic [ADDR_W-1:0] a = 40'h12_3456_7ABC ^ (40'(i) * 40'h1_0203_0F1F);
      logic [2:0] e = expClass(s, u, c, x);
      bit ex = (e >= 3'd2);
      string tag;
      case (e)
        3'd0: tag = "R1";
        3'd1: tag = "R4";
        3'd2: tag = "R3";
        3'd3: tag = "R2";
        default: tag = "R5";
      endcase
      doClear();
      sendEvent(s, u, c, x, a, 1'b0);
      chk(classValid && classCode == e, tag, classCode, e);
      chk(excPulse == ex && cmciPulse == !ex, {tag, " R13 path"}, {excPulse, cmciPulse}, {ex, !ex});
      chk(fatalFlag == (e == 3'd4), "R5 fatal", fatalFlag, e == 3'd4);
      chk(pageFrame == FRAME_W'(a >> 12), "R7 frame", pageFrame, a >> 12);
      chk(logValid && !logOverflow && logClass == e && logSource == s && logFrame == FRAME_W'(a >> 12),
          "R8 capture", {logValid, logOverflow, logClass, logSource}, {2'b10, e, s});
      @(negedge clk);
      chk(!classValid && !excPulse && !cmciPulse && !fatalFlag, "R6 single cycle",
          {classValid, excPulse, cmciPulse, fatalFlag}, 0);
    end

    // log sequencing
    doClear();
    chk(!logValid && !logOverflow, "R11 clear", {logValid, logOverflow}, 0);
    sendEvent(3'd4, 1, 0, 0, 40'h00_0000_5000, 0);   // UCNA
    chk(logValid && logClass == 1 && !logOverflow, "R8 first entry", logClass, 1);
    sendEvent(3'd2, 0, 0, 0, 40'h00_0000_6000, 0);   // CE, lower
    chk(logClass == 1 && logSource == 4 && logFrame == 5, "R10 keep on lower", logClass, 1);
    chk(logOverflow, "R9 overflow set", logOverflow, 1);
    sendEvent(3'd1, 1, 1, 0, 40'h00_0000_7000, 0);   // SRAR from IFU, higher
    chk(logClass == 3 && logSource == 1 && logFrame == 7, "R10 replace on higher", logSource, 1);
    chk(logOverflow, "R9 overflow sticky", logOverflow, 1);
    sendEvent(3'd0, 1, 1, 0, 40'h00_0000_8000, 0);   // SRAR from DCU, equal
    chk(logClass == 3 && logSource == 1 && logFrame == 7, "R10 keep on equal", logSource, 1);
    repeat (3) @(negedge clk);
    chk(logValid && logOverflow, "R9 held while idle", {logValid, logOverflow}, 3);
    doClear();
    chk(!logValid && !logOverflow, "R11 clear full", {logValid, logOverflow}, 0);
    sendEvent(3'd0, 1, 1, 0, 40'h00_0000_9000, 0);   // DCU SRAR into empty log
    chk(logClass == 3 && logSource == 0 && !logOverflow, "R8 DCU entry", logSource, 0);
    sendEvent(3'd2, 0, 0, 0, 40'h00_0000_A000, 1);   // CE with clear same cycle
    chk(logValid && logClass == 0 && logSource == 2 && logFrame == 10 && !logOverflow,
        "R11 clear with event", {logValid, logOverflow, logClass}, {2'b10, 3'd0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule